// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a requested I2C bus rate, given in kHz, into the three numbers that shape a master's SCL clock. These are a prescaler for the functional clock and two phase counts, one for the low part of the SCL period and one for the high part. It then uses those numbers to run a free-running SCL waveform. The functional clock frequency is fixed when the block is built.

Rates above 100 kHz use the fast setting. That setting targets a 9600 kHz internal tick and splits the period about two thirds low and one third high. Rates of 100 kHz and below target a 4000 kHz tick and split the period evenly. A fixed trim is subtracted from each phase count. The block also reports a status wait delay that spans roughly twenty SCL periods. If any resulting count or the prescaler is not positive, the request is rejected and SCL stays idle.

A request is a one-cycle `start_i` pulse with the rate on `speed_khz_i`. The divisions run on one shared serial divider, so results arrive some tens of cycles later, marked by a one-cycle `done_o`.

Top module: `i2c_scl_timing`

## Requirements
- R1: A rate strictly above 100 kHz selects fast timing. A rate of 100 kHz or less selects standard timing. With the default 48000 kHz functional clock, fast gives prescaler 4 and standard gives prescaler 11.
- R2: The prescaler output is the functional clock in kHz divided (integer) by the mode's internal tick rate (9600 kHz fast, 4000 kHz standard), minus one.
- R3: In fast timing, let P = 9600 / rate and T = P / 3 (integer division). The low count is P − T − 7 and the high count is T − 5.
- R4: In standard timing, let H = 4000 / (2 × rate). The low count is H − 7 and the high count is H − 5.
- R5: The error output is raised when the low count, the high count or the prescaler would be zero or negative, or when the rate is 0. While the error output is raised, the low count, high count and wait delay outputs read 0.
- R6: For a valid request, the wait delay output equals (10000000 / rate) × 2.
- R7: Each accepted start produces exactly one `done_o` pulse, one cycle wide. `busy_o` is high from the cycle after acceptance until the cycle of `done_o`. A start while busy is ignored: it produces no extra pulse and does not change the results.
- R8: The error output holds its value from the `done_o` cycle until the next accepted start. It reads 0 from the cycle after that start.
- R9: After a valid result, SCL repeats a low phase of (low+1)×(prescaler+1) clock cycles and a high phase of (high+1)×(prescaler+1) clock cycles.
- R10: SCL is held at 1 while busy, while an error is held, and before any valid result.
- R11: After reset, busy, done and error read 0, the low, high and wait outputs read 0, and SCL reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to compute timing for `speed_khz_i` |
| speed_khz_i | input | SPD_W (16) | Requested bus rate in kHz |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| err_o | output | 1 | Invalid configuration, held until next accepted start |
| presc_o | output | PSC_W (8) | Functional clock prescaler value |
| scl_low_o | output | CNT_W (16) | SCL low phase count |
| scl_high_o | output | CNT_W (16) | SCL high phase count |
| wait_dly_o | output | DW (32) | Status wait delay |
| scl_o | output | 1 | Generated SCL waveform |

## Verification
The bench targets the point where the mode changes. At 100 kHz the standard split must be used, and at 101 kHz the fast one. A design that compares with the wrong relation swaps both the prescaler and the split. It also targets the zero boundaries. At 640 kHz the high count is exactly zero and at 800 kHz it goes negative; a design that only tests for negative values accepts the first. A rate of zero must be rejected without reaching the divider, or the design would hang or report garbage. A start issued while busy must neither restart the sequence nor add a second done pulse. The measured SCL phase lengths expose any off-by-one in either the tick divider or the phase counters.

// File: rtl/sclt_pkg.sv
package sclt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PER_GO,
      ST_PER_WT,
      ST_THR_GO,
      ST_THR_WT,
      ST_DLY_GO,
      ST_DLY_WT,
      ST_FIN
   } calc_st_e;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } scl_phase_e;

endpackage

// File: rtl/sclt_divider.sv
module sclt_divider #(
   parameter int W         = 32,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quo_o
);

   localparam int CW = $clog2(W + 1);

   generate
      if (ITERATIVE) begin : g_serial
         logic [W-1:0]  q_r, r_r, d_r;
         logic [CW-1:0] cnt_r;
         logic          run_r, done_r;
         logic [W:0]    r_sh;
         logic          fits;

         assign r_sh = {r_r, q_r[W-1]};
         assign fits = (r_sh >= {1'b0, d_r});

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_r    <= '0;
               r_r    <= '0;
               d_r    <= '0;
               cnt_r  <= '0;
               run_r  <= 1'b0;
               done_r <= 1'b0;
            end else if (go_i && !run_r) begin
               q_r    <= num_i;
               r_r    <= '0;
               d_r    <= den_i;
               cnt_r  <= CW'(W);
               run_r  <= 1'b1;
               done_r <= 1'b0;
            end else if (run_r) begin
               if (fits) begin
                  r_r <= W'(r_sh - {1'b0, d_r});
                  q_r <= {q_r[W-2:0], 1'b1};
               end else begin
                  r_r <= W'(r_sh);
                  q_r <= {q_r[W-2:0], 1'b0};
               end
               cnt_r <= cnt_r - 1'b1;
               if (cnt_r == CW'(1)) begin
                  run_r  <= 1'b0;
                  done_r <= 1'b1;
               end
            end else begin
               done_r <= 1'b0;
            end
         end

         assign busy_o = run_r;
         assign done_o = done_r;
         assign quo_o  = q_r;

         p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_r <= CW'(W));
      end else begin : g_flat
         logic [W-1:0] q_r;
         logic         done_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_r    <= '0;
               done_r <= 1'b0;
            end else begin
               done_r <= go_i;
               if (go_i) q_r <= num_i / den_i;
            end
         end

         assign busy_o = 1'b0;
         assign done_o = done_r;
         assign quo_o  = q_r;
      end
   endgenerate

   p_div_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/sclt_calc.sv
module sclt_calc
   import sclt_pkg::*;
#(
   parameter int SPD_W        = 16,
   parameter int DW           = 32,
   parameter int CNT_W        = 16,
   parameter int PSC_W        = 8,
   parameter int FCLK_KHZ     = 48000,
   parameter int FAST_INT_KHZ = 9600,
   parameter int STD_INT_KHZ  = 4000,
   parameter int FAST_MIN_KHZ = 100,
   parameter int TRIM_LO      = 7,
   parameter int TRIM_HI      = 5,
   parameter int DLY_NUM      = 10000000,
   parameter bit ITERATIVE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SPD_W-1:0] speed_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic             valid_o,
   output logic [PSC_W-1:0] presc_o,
   output logic [CNT_W-1:0] low_o,
   output logic [CNT_W-1:0] high_o,
   output logic [DW-1:0]    wait_o
);

   localparam int SW         = DW + 2;
   localparam int PSC_FAST_I = FCLK_KHZ / FAST_INT_KHZ - 1;
   localparam int PSC_STD_I  = FCLK_KHZ / STD_INT_KHZ - 1;
   localparam bit PSC_FAST_BAD = (PSC_FAST_I <= 0);
   localparam bit PSC_STD_BAD  = (PSC_STD_I <= 0);

   calc_st_e          st_q;
   logic [SPD_W-1:0]  spd_q;
   logic              fast_q, zero_q;
   logic [DW-1:0]     per_q, thr_q, dly_q;
   logic              done_q, err_q, valid_q;
   logic [PSC_W-1:0]  psc_q;
   logic [CNT_W-1:0]  low_q, high_q;
   logic [DW-1:0]     wait_q;

   logic              div_go, div_busy, div_done;
   logic [DW-1:0]     div_num, div_den, div_quo;

   logic signed [SW-1:0] per_s, thr_s, low_s, high_s;
   logic                 psc_bad, cfg_bad;

   always_comb begin
      div_go  = 1'b0;
      div_num = '0;
      div_den = DW'(1);
      unique case (st_q)
         ST_PER_GO: begin
            div_go  = 1'b1;
            div_num = fast_q ? DW'(FAST_INT_KHZ) : DW'(STD_INT_KHZ);
            div_den = fast_q ? DW'(spd_q) : DW'({spd_q, 1'b0});
         end
         ST_THR_GO: begin
            div_go  = 1'b1;
            div_num = per_q;
            div_den = DW'(3);
         end
         ST_DLY_GO: begin
            div_go  = 1'b1;
            div_num = DW'(DLY_NUM);
            div_den = DW'(spd_q);
         end
         default: ;
      endcase
   end

   sclt_divider #(
      .W         (DW),
      .ITERATIVE (ITERATIVE)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (div_num),
      .den_i  (div_den),
      .busy_o (div_busy),
      .done_o (div_done),
      .quo_o  (div_quo)
   );

   always_comb begin
      per_s = $signed({2'b00, per_q});
      thr_s = $signed({2'b00, thr_q});
      if (fast_q) begin
         low_s  = per_s - thr_s - SW'(TRIM_LO);
         high_s = thr_s - SW'(TRIM_HI);
      end else begin
         low_s  = per_s - SW'(TRIM_LO);
         high_s = per_s - SW'(TRIM_HI);
      end
      psc_bad = fast_q ? PSC_FAST_BAD : PSC_STD_BAD;
      cfg_bad = zero_q || psc_bad || (low_s <= 0) || (high_s <= 0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         spd_q   <= '0;
         fast_q  <= 1'b0;
         zero_q  <= 1'b0;
         per_q   <= '0;
         thr_q   <= '0;
         dly_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         valid_q <= 1'b0;
         psc_q   <= '0;
         low_q   <= '0;
         high_q  <= '0;
         wait_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  spd_q   <= speed_i;
                  fast_q  <= (speed_i > SPD_W'(FAST_MIN_KHZ));
                  zero_q  <= (speed_i == '0);
                  per_q   <= '0;
                  thr_q   <= '0;
                  dly_q   <= '0;
                  err_q   <= 1'b0;
                  valid_q <= 1'b0;
                  st_q    <= (speed_i == '0) ? ST_FIN : ST_PER_GO;
               end
            end
            ST_PER_GO: st_q <= ST_PER_WT;
            ST_PER_WT: begin
               if (div_done) begin
                  per_q <= div_quo;
                  st_q  <= fast_q ? ST_THR_GO : ST_DLY_GO;
               end
            end
            ST_THR_GO: st_q <= ST_THR_WT;
            ST_THR_WT: begin
               if (div_done) begin
                  thr_q <= div_quo;
                  st_q  <= ST_DLY_GO;
               end
            end
            ST_DLY_GO: st_q <= ST_DLY_WT;
            ST_DLY_WT: begin
               if (div_done) begin
                  dly_q <= div_quo;
                  st_q  <= ST_FIN;
               end
            end
            ST_FIN: begin
               psc_q   <= fast_q ? PSC_W'(PSC_FAST_I) : PSC_W'(PSC_STD_I);
               err_q   <= cfg_bad;
               valid_q <= !cfg_bad;
               low_q   <= cfg_bad ? '0 : CNT_W'(low_s);
               high_q  <= cfg_bad ? '0 : CNT_W'(high_s);
               wait_q  <= cfg_bad ? '0 : (dly_q << 1);
               done_q  <= 1'b1;
               st_q    <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (st_q != ST_IDLE);
   assign done_o  = done_q;
   assign err_o   = err_q;
   assign valid_o = valid_q;
   assign presc_o = psc_q;
   assign low_o   = low_q;
   assign high_o  = high_q;
   assign wait_o  = wait_q;

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(spd_q));
   p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (low_q == '0 && high_q == '0 && wait_q == '0));
   p_valid_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_q && err_q));
   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(err_q));
   p_div_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !div_busy);

endmodule

// File: rtl/sclt_wave.sv
module sclt_wave
   import sclt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [PSC_W-1:0] presc_i,
   input  logic [CNT_W-1:0] low_i,
   input  logic [CNT_W-1:0] high_i,
   output logic             scl_o
);

   logic             en_q;
   logic [PSC_W-1:0] tick_q;
   logic [CNT_W-1:0] ph_cnt_q;
   scl_phase_e       ph_q;
   logic [CNT_W-1:0] ph_lim;
   logic             tick_end;

   assign ph_lim   = (ph_q == PH_HIGH) ? high_i : low_i;
   assign tick_end = (tick_q == presc_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         tick_q   <= '0;
         ph_cnt_q <= '0;
         ph_q     <= PH_LOW;
      end else if (!run_i) begin
         en_q     <= 1'b0;
         tick_q   <= '0;
         ph_cnt_q <= '0;
         ph_q     <= PH_LOW;
      end else if (!en_q) begin
         en_q <= 1'b1;
      end else if (tick_end) begin
         tick_q <= '0;
         if (ph_cnt_q == ph_lim) begin
            ph_cnt_q <= '0;
            ph_q     <= (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
         end else begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
         end
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   assign scl_o = (en_q && run_i) ? (ph_q == PH_HIGH) : 1'b1;

   p_tick_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (tick_q <= presc_i));
   p_phase_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (ph_cnt_q <= ph_lim));
   p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !en_q);

endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing #(
   parameter int SPD_W        = 16,
   parameter int DW           = 32,
   parameter int CNT_W        = 16,
   parameter int PSC_W        = 8,
   parameter int FCLK_KHZ     = 48000,
   parameter int FAST_INT_KHZ = 9600,
   parameter int STD_INT_KHZ  = 4000,
   parameter int FAST_MIN_KHZ = 100,
   parameter int TRIM_LO      = 7,
   parameter int TRIM_HI      = 5,
   parameter int DLY_NUM      = 10000000,
   parameter bit ITERATIVE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SPD_W-1:0] speed_khz_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic [PSC_W-1:0] presc_o,
   output logic [CNT_W-1:0] scl_low_o,
   output logic [CNT_W-1:0] scl_high_o,
   output logic [DW-1:0]    wait_dly_o,
   output logic             scl_o
);

   localparam int STD_HALF_MAX = STD_INT_KHZ / 2;
   localparam int PSC_MAX      = FCLK_KHZ / STD_INT_KHZ;

   generate
      if (FAST_INT_KHZ <= 0 || STD_INT_KHZ <= 0) begin : g_bad_int
         $error("internal tick rates must be positive");
      end
      if (DW <= SPD_W + 1) begin : g_bad_dw
         $error("DW must exceed SPD_W + 1");
      end
      if (STD_HALF_MAX >= (1 << CNT_W) || FAST_INT_KHZ >= (1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for phase counts");
      end
      if (PSC_MAX > (1 << PSC_W)) begin : g_bad_psc
         $error("PSC_W too narrow for prescaler");
      end
      if (TRIM_LO < 0 || TRIM_HI < 0) begin : g_bad_trim
         $error("trim constants must be non-negative");
      end
      if (DLY_NUM <= 0 || DW < 26) begin : g_bad_dly
         $error("wait delay numerator or width invalid");
      end
   endgenerate

   logic valid_w;

   sclt_calc #(
      .SPD_W        (SPD_W),
      .DW           (DW),
      .CNT_W        (CNT_W),
      .PSC_W        (PSC_W),
      .FCLK_KHZ     (FCLK_KHZ),
      .FAST_INT_KHZ (FAST_INT_KHZ),
      .STD_INT_KHZ  (STD_INT_KHZ),
      .FAST_MIN_KHZ (FAST_MIN_KHZ),
      .TRIM_LO      (TRIM_LO),
      .TRIM_HI      (TRIM_HI),
      .DLY_NUM      (DLY_NUM),
      .ITERATIVE    (ITERATIVE)
   ) u_calc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .speed_i (speed_khz_i),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .err_o   (err_o),
      .valid_o (valid_w),
      .presc_o (presc_o),
      .low_o   (scl_low_o),
      .high_o  (scl_high_o),
      .wait_o  (wait_dly_o)
   );

   sclt_wave #(
      .CNT_W (CNT_W),
      .PSC_W (PSC_W)
   ) u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (valid_w),
      .presc_i (presc_o),
      .low_i   (scl_low_o),
      .high_i  (scl_high_o),
      .scl_o   (scl_o)
   );

   p_busy_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> scl_o);
   p_err_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> scl_o);
   p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o));

endmodule

// File: tb/i2c_scl_timing_bench.sv
`timescale 1ns/1ps
module i2c_scl_timing_bench;

   localparam int FCLK = 48000;

   typedef struct {
      int spd;
      int psc;
      int lo;
      int hi;
      int wt;
      int err;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] speed_khz_i = '0;
   logic        busy_o, done_o, err_o, scl_o;
   logic [7:0]  presc_o;
   logic [15:0] scl_low_o, scl_high_o;
   logic [31:0] wait_dly_o;

   int checks = 0;
   int errors = 0;
   int n_done = 0;
   bit finished = 1'b0;
   exp_t sb[$];

   always #10 clk = ~clk;

   i2c_scl_timing u_i2c_scl_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .speed_khz_i (speed_khz_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .presc_o     (presc_o),
      .scl_low_o   (scl_low_o),
      .scl_high_o  (scl_high_o),
      .wait_dly_o  (wait_dly_o),
      .scl_o       (scl_o)
   );

   task automatic check(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic exp_t model(int spd);
      exp_t e;
      int ic, per, thr;
      bit fast;
      fast  = (spd > 100);
      ic    = fast ? 9600 : 4000;
      e.spd = spd;
      e.psc = FCLK / ic - 1;
      if (spd == 0) begin
         e.lo = 0; e.hi = 0; e.wt = 0; e.err = 1;
         return e;
      end
      if (fast) begin
         per  = ic / spd;
         thr  = per / 3;
         e.lo = per - thr - 7;
         e.hi = thr - 5;
      end else begin
         per  = ic / (2 * spd);
         e.lo = per - 7;
         e.hi = per - 5;
      end
      e.wt  = (10000000 / spd) * 2;
      e.err = (e.lo <= 0 || e.hi <= 0 || e.psc <= 0) ? 1 : 0;
      if (e.err != 0) begin
         e.lo = 0; e.hi = 0; e.wt = 0;
      end
      return e;
   endfunction

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         n_done++;
         if (sb.size() == 0) begin
            check("R7 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check($sformatf("R1/R2 presc spd=%0d", e.spd), presc_o, e.psc);
            check($sformatf("R3/R4 low spd=%0d", e.spd), scl_low_o, e.lo);
            check($sformatf("R3/R4 high spd=%0d", e.spd), scl_high_o, e.hi);
            check($sformatf("R6 wait spd=%0d", e.spd), wait_dly_o, e.wt);
            check($sformatf("R5 err spd=%0d", e.spd), err_o, e.err);
         end
      end
   end

   task automatic pulse_start(int spd);
      @(negedge clk);
      speed_khz_i = 16'(spd);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_cfg(int spd);
      int tgt;
      bit low_seen;
      tgt = n_done + 1;
      low_seen = 1'b0;
      sb.push_back(model(spd));
      pulse_start(spd);
      while (n_done < tgt) begin
         if (busy_o && !scl_o) low_seen = 1'b1;
         @(negedge clk);
      end
      check($sformatf("R10 scl high while busy spd=%0d", spd), low_seen, 0);
   endtask

   task automatic measure(int exp_lo, int exp_hi, string tag);
      int lo_n, hi_n;
      for (int k = 0; k < 2; k++) begin
         while (scl_o) @(negedge clk);
         while (!scl_o) @(negedge clk);
      end
      lo_n = 0;
      hi_n = 0;
      while (scl_o) begin hi_n++; @(negedge clk); end
      while (!scl_o) begin lo_n++; @(negedge clk); end
      check({"R9 low len ", tag}, lo_n, exp_lo);
      check({"R9 high len ", tag}, hi_n, exp_hi);
   endtask

   initial begin
      int held;
      int base;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 busy", busy_o, 0);
      check("R11 done", done_o, 0);
      check("R11 err", err_o, 0);
      check("R11 scl", scl_o, 1);
      check("R11 low", scl_low_o, 0);
      check("R11 high", scl_high_o, 0);
      check("R11 wait", wait_dly_o, 0);

      run_cfg(100);                 // R4 standard at boundary
      measure(168, 192, "100k");
      run_cfg(400);                 // R3 fast
      measure(50, 20, "400k");
      run_cfg(533);
      measure(30, 10, "533k");
      run_cfg(101);                 // R1 fast just above boundary
      run_cfg(50);
      run_cfg(1);

      run_cfg(1000);                // R5 negative counts
      held = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (err_o && scl_o) held++;
      end
      check("R8/R10 err held with scl idle", held, 300);

      // R8 err cleared after next accepted start
      base = n_done;
      sb.push_back(model(640));     // high count exactly zero
      pulse_start(640);
      @(negedge clk);
      check("R8 err cleared after start", err_o, 0);
      while (n_done == base) @(negedge clk);

      run_cfg(800);
      run_cfg(0);                   // R5 zero rate

      // R7 start while busy is ignored
      base = n_done;
      sb.push_back(model(400));
      pulse_start(400);
      repeat (3) @(negedge clk);
      speed_khz_i = 16'd100;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (n_done == base) @(negedge clk);
      repeat (200) @(negedge clk);
      check("R7 single done for busy start", n_done - base, 1);
      check("R9 low after ignored start", scl_low_o, 9);

      run_cfg(100);
      check("R7 scoreboard drained", sb.size(), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R7 actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule